// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a 32-bit processor core that completes one instruction on every rising clock edge. Each cycle it fetches a word from its instruction store and decodes the opcode. It reads two operands from a 32-entry register file, runs the ALU, and may touch its data store. It then commits the register result and the next program counter at that same edge. The instruction set is small: five register-to-register operations (add, subtract, and, or, signed set-less-than), word load, word store, branch-if-equal and an absolute jump.

Instruction and data storage are separate word arrays inside the block. Because every step of an instruction happens in a single cycle, the core has two separate adders: one forms PC+4 and one forms the branch target. Both stores are filled through a load port while reset is held high. During execution, three groups of outputs show the core's progress: the current program counter and instruction, the register writeback of the current instruction, and the store bus. A system, or a bench, uses these outputs to follow execution without reaching into the core.

Top module: `sc_core`

## Requirements
- R1: With `rst` high at a rising edge, the program counter becomes 0 (synchronous, active high), and no register or data-store write from execution takes place.
- R2: An instruction that is not a taken branch and not a jump sets the next program counter to the current value plus 4. The instruction word is fetched from word index pc[IMEM_AW+1:2].
- R3: Instruction fields are decoded as follows. The opcode is in bits 31:26: 000000 for register operations, 100011 for load, 101011 for store, 000100 for branch-if-equal and 000010 for jump. The first source is bits 25:21 and the second source is bits 20:16. A register operation writes to bits 15:11 and uses bits 5:0 as the function code. A load writes to bits 20:16. Loads, stores and branches take bits 15:0 as an offset, sign-extended to 32 bits.
- R4: Register operations write the following results to the destination register. Function 100000 writes the sum, 100010 the difference (first minus second), 100100 the bitwise and, and 100101 the bitwise or. Function 101010 writes 1 if the first source is less than the second as signed numbers, and 0 otherwise.
- R5: A load writes the data-store word at address (first source + offset) to register bits 20:16. The word index is address bits DMEM_AW+1:2.
- R6: A store raises `st_en` for the cycle and presents the address (first source + offset) and the second-source value. The store writes the data store at the clock edge and does not write any register.
- R7: Branch-if-equal sets the next program counter to PC+4+(offset<<2) when its two sources are equal, and to PC+4 otherwise. Negative offsets branch backwards.
- R8: A jump sets the next program counter to {pc[31:28], instr[25:0], 2'b00}.
- R9: Register 0 always reads as zero. A write aimed at it is dropped, and `wb_en` stays low for that instruction.
- R10: While `rst` is high, a cycle with `load_en` high writes `load_data` into the instruction store (`load_dmem`=0) or the data store (`load_dmem`=1) at word `load_addr`.
- R11: `wb_en`, `wb_reg` and `wb_data` show, within the same cycle, the register write that the current instruction commits at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; also enables the load port |
| load_en | input | 1 | Write one word into a store during reset |
| load_dmem | input | 1 | Store select for the load port: 0 instruction, 1 data |
| load_addr | input | LAW | Word index for the load port |
| load_data | input | 32 | Word written by the load port |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction word at the current program counter |
| st_en | output | 1 | Current instruction stores to the data store |
| st_addr | output | 32 | Byte address of the store |
| st_data | output | 32 | Data being stored |
| wb_en | output | 1 | Current instruction writes a nonzero register |
| wb_reg | output | 5 | Destination register of the write |
| wb_data | output | 32 | Value written |

## Verification
A fixed program is run against six operand pairs placed in the data store. The pairs are small positive values, equal values, mixed signs, the most negative number against one, all-ones against itself, and a value against its negation. These pairs separate signed from unsigned set-less-than, exercise wrap-around in add and subtract, and steer the branch both ways so that taken and fall-through paths are both covered. Within the program, a load of a word that an earlier store wrote shows the store really reached memory. A write to register 0 followed by a read of it shows the write was dropped. A self-branch with offset -1 checks backward targets, and the jump over the equal-path store checks the jump target.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN = 32;

    localparam logic [5:0] OPC_REG   = 6'b000000;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;
    localparam logic [5:0] OPC_JUMP  = 6'b000010;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [1:0] {
        CLS_ADD  = 2'b00,
        CLS_SUB  = 2'b01,
        CLS_FUNC = 2'b10
    } alu_class_e;

    typedef enum logic [2:0] {
        ALU_AND,
        ALU_OR,
        ALU_ADD,
        ALU_SUB,
        ALU_SLT
    } alu_op_e;

    typedef struct packed {
        logic       dst_is_rd;
        logic       b_is_imm;
        logic       wb_from_mem;
        logic       reg_we;
        logic       mem_re;
        logic       mem_we;
        logic       is_branch;
        logic       is_jump;
        alu_class_e alu_class;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl,
    output alu_op_e    alu_op
);

    always_comb begin
        ctrl = '0;
        ctrl.alu_class = CLS_ADD;
        case (opcode)
            OPC_REG: begin
                ctrl.dst_is_rd = 1'b1;
                ctrl.reg_we    = 1'b1;
                ctrl.alu_class = CLS_FUNC;
            end
            OPC_LOAD: begin
                ctrl.b_is_imm    = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.reg_we      = 1'b1;
                ctrl.mem_re      = 1'b1;
            end
            OPC_STORE: begin
                ctrl.b_is_imm = 1'b1;
                ctrl.mem_we   = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_class = CLS_SUB;
            end
            OPC_JUMP: begin
                ctrl.is_jump = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end

    always_comb begin
        unique case (ctrl.alu_class)
            CLS_SUB:  alu_op = ALU_SUB;
            CLS_FUNC: begin
                case (funct)
                    FN_SUB:  alu_op = ALU_SUB;
                    FN_AND:  alu_op = ALU_AND;
                    FN_OR:   alu_op = ALU_OR;
                    FN_SLT:  alu_op = ALU_SLT;
                    default: alu_op = ALU_ADD;
                endcase
            end
            default:  alu_op = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         zero
);

    always_comb begin
        unique case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int W    = 32,
    parameter int NREG = 32,
    localparam int RW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [RW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [RW-1:0] raddr_a,
    input  logic [RW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);

    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_AW = 6,
    parameter int DMEM_AW = 6,
    localparam int LAW    = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_en,
    input  logic            load_dmem,
    input  logic [LAW-1:0]  load_addr,
    input  logic [31:0]     load_data,
    output logic [31:0]     pc_o,
    output logic [31:0]     instr_o,
    output logic            st_en,
    output logic [31:0]     st_addr,
    output logic [31:0]     st_data,
    output logic            wb_en,
    output logic [4:0]      wb_reg,
    output logic [31:0]     wb_data
);

    localparam int IWORDS = 1 << IMEM_AW;
    localparam int DWORDS = 1 << DMEM_AW;

    logic [31:0] imem [IWORDS];
    logic [31:0] dmem [DWORDS];

    logic [31:0] pc, pc_next, pc_plus4, br_target, jmp_target;
    logic [31:0] instr, imm_ext, rs_val, rt_val, alu_b, alu_y, mem_rdata;
    logic [4:0]  dst;
    logic        alu_zero, take_branch;
    ctrl_t       ctrl;
    alu_op_e     alu_op;

    // fetch
    assign instr = imem[pc[IMEM_AW+1:2]];

    sc_decode u_dec (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl),
        .alu_op (alu_op)
    );

    assign imm_ext = {{16{instr[15]}}, instr[15:0]};
    assign dst     = ctrl.dst_is_rd ? instr[15:11] : instr[20:16];

    sc_regfile #(.W(32), .NREG(32)) u_rf (
        .clk     (clk),
        .we      (ctrl.reg_we && !rst),
        .waddr   (dst),
        .wdata   (wb_data),
        .raddr_a (instr[25:21]),
        .raddr_b (instr[20:16]),
        .rdata_a (rs_val),
        .rdata_b (rt_val)
    );

    assign alu_b = ctrl.b_is_imm ? imm_ext : rt_val;

    sc_alu #(.W(32)) u_alu (
        .op   (alu_op),
        .a    (rs_val),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign mem_rdata = dmem[alu_y[DMEM_AW+1:2]];

    // two dedicated adders: sequential address and branch target
    assign pc_plus4    = pc + 32'd4;
    assign br_target   = pc_plus4 + {imm_ext[29:0], 2'b00};
    assign jmp_target  = {pc[31:28], instr[25:0], 2'b00};
    assign take_branch = ctrl.is_branch && alu_zero;

    always_comb begin
        if (ctrl.is_jump)      pc_next = jmp_target;
        else if (take_branch)  pc_next = br_target;
        else                   pc_next = pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
            if (load_en && !load_dmem) begin
                imem[load_addr[IMEM_AW-1:0]] <= load_data;
            end
        end else begin
            pc <= pc_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            if (load_en && load_dmem) begin
                dmem[load_addr[DMEM_AW-1:0]] <= load_data;
            end
        end else if (ctrl.mem_we) begin
            dmem[alu_y[DMEM_AW+1:2]] <= rt_val;
        end
    end

    assign pc_o    = pc;
    assign instr_o = instr;
    assign st_en   = ctrl.mem_we;
    assign st_addr = alu_y;
    assign st_data = rt_val;
    assign wb_en   = ctrl.reg_we && (dst != 5'd0);
    assign wb_reg  = dst;
    assign wb_data = ctrl.wb_from_mem ? mem_rdata : alu_y;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc_o,
    input logic [31:0] instr_o,
    input logic        st_en,
    input logic        wb_en,
    input logic [4:0]  wb_reg
);

    localparam logic [5:0] C_STORE = 6'b101011;
    localparam logic [5:0] C_BEQ   = 6'b000100;
    localparam logic [5:0] C_JUMP  = 6'b000010;

    // R1: reset forces the program counter to zero on the next edge
    p_pc_reset_r1: assert property (@(posedge clk)
        rst |=> (pc_o == 32'd0));

    // R2: plain instructions advance by one word
    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        ((instr_o[31:26] != C_BEQ) && (instr_o[31:26] != C_JUMP))
        |=> (pc_o == $past(pc_o) + 32'd4));

    // R2: program counter stays word aligned
    p_pc_aligned_r2: assert property (@(posedge clk) disable iff (rst)
        (pc_o[1:0] == 2'b00));

    // R8: jump target formed from current upper bits and the index field
    p_jump_target_r8: assert property (@(posedge clk) disable iff (rst)
        (instr_o[31:26] == C_JUMP)
        |=> (pc_o == {$past(pc_o[31:28]), $past(instr_o[25:0]), 2'b00}));

    // R6: the store bus is active only for the store opcode, never with a writeback
    p_store_only_r6: assert property (@(posedge clk) disable iff (rst)
        st_en |-> ((instr_o[31:26] == C_STORE) && !wb_en));

    // R9: no visible writeback aims at register 0
    p_no_zero_write_r9: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (wb_reg != 5'd0));

endmodule

bind sc_core sc_core_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .pc_o    (pc_o),
    .instr_o (instr_o),
    .st_en   (st_en),
    .wb_en   (wb_en),
    .wb_reg  (wb_reg)
);

// File: tb/sim_sc_core.sv
module sim_sc_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_en = 1'b0;
    logic        load_dmem = 1'b0;
    logic [5:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [31:0] pc_o, instr_o, st_addr, st_data, wb_data;
    logic        st_en, wb_en;
    logic [4:0]  wb_reg;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sc_core u0 (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .load_dmem (load_dmem),
        .load_addr (load_addr),
        .load_data (load_data),
        .pc_o      (pc_o),
        .instr_o   (instr_o),
        .st_en     (st_en),
        .st_addr   (st_addr),
        .st_data   (st_data),
        .wb_en     (wb_en),
        .wb_reg    (wb_reg),
        .wb_data   (wb_data)
    );

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                          input logic [5:0] fn);
        return {6'b000000, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs,
                                          input int rt, input int imm);
        return {op, rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    function automatic logic [31:0] enc_j(input int tgt);
        return {6'b000010, tgt[25:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_wb(input string req, input int r, input logic [31:0] v);
        chk(wb_en === 1'b1, req, {31'd0, wb_en}, 32'd1);
        chk(wb_reg === r[4:0], req, {27'd0, wb_reg}, r);
        chk(wb_data === v, req, wb_data, v);
    endtask

    task automatic chk_st(input string req, input logic [31:0] ad, input logic [31:0] v);
        chk(st_en === 1'b1, req, {31'd0, st_en}, 32'd1);
        chk(st_addr === ad, req, st_addr, ad);
        chk(st_data === v, req, st_data, v);
        chk(wb_en === 1'b0, req, {31'd0, wb_en}, 32'd0);
    endtask

    task automatic chk_pc(input string req, input logic [31:0] v);
        chk(pc_o === v, req, pc_o, v);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic put(input bit dsel, input int idx, input logic [31:0] w);
        @(negedge clk);
        load_en   = 1'b1;
        load_dmem = dsel;
        load_addr = idx[5:0];
        load_data = w;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic run_pair(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] prog [16];
        bit eq;
        eq = (a == b);
        prog[0]  = enc_i(6'b100011, 0, 1, 0);
        prog[1]  = enc_i(6'b100011, 0, 2, 4);
        prog[2]  = enc_r(1, 2, 3, 6'b100000);
        prog[3]  = enc_r(1, 2, 4, 6'b100010);
        prog[4]  = enc_r(1, 2, 5, 6'b100100);
        prog[5]  = enc_r(1, 2, 6, 6'b100101);
        prog[6]  = enc_r(1, 2, 7, 6'b101010);
        prog[7]  = enc_r(1, 1, 0, 6'b100000);
        prog[8]  = enc_r(0, 0, 9, 6'b100101);
        prog[9]  = enc_i(6'b101011, 0, 3, 8);
        prog[10] = enc_i(6'b000100, 1, 2, 2);
        prog[11] = enc_i(6'b101011, 0, 4, 12);
        prog[12] = enc_j(14);
        prog[13] = enc_i(6'b101011, 0, 5, 16);
        prog[14] = enc_i(6'b100011, 0, 8, 8);
        prog[15] = enc_i(6'b000100, 0, 0, -1);

        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 16; i++) put(1'b0, i, prog[i]);
        put(1'b1, 0, a);
        put(1'b1, 1, b);
        put(1'b1, 2, 32'd0);
        // R1: held in reset the counter reads zero
        chk_pc("R1", 32'd0);
        rst = 1'b0;

        chk_pc("R2", 32'd0);
        chk_wb("R5 load a", 1, a);                            step();
        chk_pc("R2", 32'd4);
        chk_wb("R5 load b", 2, b);                            step();
        chk_wb("R4 add", 3, a + b);                           step();
        chk_wb("R4 sub", 4, a - b);                           step();
        chk_wb("R4 and", 5, a & b);                           step();
        chk_wb("R4 or", 6, a | b);                            step();
        chk_wb("R4 slt", 7, ($signed(a) < $signed(b)) ? 32'd1 : 32'd0); step();
        chk_pc("R3", 32'd28);
        chk(wb_en === 1'b0, "R9 write r0", {31'd0, wb_en}, 32'd0); step();
        chk_wb("R9 read r0", 9, 32'd0);                       step();
        chk_st("R6 store sum", 32'd8, a + b);                 step();
        chk_pc("R11", 32'd40);                                step();
        if (eq) begin
            chk_pc("R7 taken", 32'd52);
            chk_st("R6 store and", 32'd16, a & b);            step();
        end else begin
            chk_pc("R7 not taken", 32'd44);
            chk_st("R6 store diff", 32'd12, a - b);           step();
            chk_pc("R2", 32'd48);                             step();
        end
        chk_pc("R8 jump", 32'd56);
        chk_wb("R5 reload sum", 8, a + b);                    step();
        chk_pc("R2", 32'd60);                                 step();
        chk_pc("R7 backward", 32'd60);                        step();
        chk_pc("R7 backward", 32'd60);
        chk(instr_o === prog[15], "R10 imem load", instr_o, prog[15]);
    endtask

    initial begin
        logic [31:0] pa [6];
        logic [31:0] pb [6];
        pa[0] = 32'd5;         pb[0] = 32'd3;
        pa[1] = 32'd7;         pb[1] = 32'd7;
        pa[2] = -32'sd2;       pb[2] = 32'd9;
        pa[3] = 32'h8000_0000; pb[3] = 32'd1;
        pa[4] = 32'hFFFF_FFFF; pb[4] = 32'hFFFF_FFFF;
        pa[5] = 32'd123456;    pb[5] = -32'sd123456;
        repeat (3) @(posedge clk);
        for (int k = 0; k < 6; k++) run_pair(pa[k], pb[k]);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule